// File: doc/BRIEF.md
# FIFO Depth-Cascade Slice Controller

This block is the control half of one slice of a deep FIFO built from several identical memory slices. All slices share the write request, read request and data lines. Which slice stores the next word, and which slice supplies the next word, depends on two tokens: a write token and a read token. The tokens travel around a ring. Each slice has an active-low expansion output that drives the active-low expansion input of the next slice, and the last slice drives the first. The controller keeps the write and read address counters and the occupancy of its own storage. It produces the write and read enables and addresses for that storage, plus full, empty and half-full flags. The storage array itself sits outside the block.

The mode is taken from two inputs during reset. If the expansion input is held low through reset, the slice runs alone as a single FIFO. In that mode it offers a half-full flag and a rewind command, which restarts reading from address zero. If the expansion input idles high during reset, the slice runs in cascade mode. The slice whose first-load input is low is the head, and the others are followers. In cascade mode the half-full flag reads low and the rewind command is ignored.

The expansion output marks the last physical address of the slice, not the last free word. A slice fires one pulse when it writes that address and hands on its write token. It fires another pulse when it reads that address and hands on its read token. A follower takes the write token from the first pulse it receives. It takes the read token from the second pulse, and after that tokens alternate between write and read. The rules at the edge of the block are plain request/enable rules. A request that the controller cannot accept leaves its enable low for that cycle. No state changes, and the requester repeats the request on a later cycle. Reset is synchronous and active low. `DEPTH` must be a power of two.

Top module: `dcas_slice_ctrl`

## Requirements
- R1: With `xi_n` low during reset (single mode), `xo_n` stays high, and `wr_en`/`rd_en` follow the requests, gated only by the full and empty flags.
- R2: In cascade mode, the head slice (`first_n` low during reset) accepts writes and reads in the first cycle after reset.
- R3: A follower (`first_n` high during reset) holds `wr_en` low until it has seen one low cycle on `xi_n`. Because the pulse is registered, one idle cycle separates the last write of the previous slice from the first write of the next slice.
- R4: A follower holds `rd_en` low until it has seen a second low cycle on `xi_n`, even if it already holds data. After that it reads only while it is not empty.
- R5: `xo_n` is high during reset and while idle. It is low for one cycle, in the cycle after a cascade write or read of address `DEPTH-1`.
- R6: After a cascade slice writes address `DEPTH-1`, it gives up its write token and holds `wr_en` low until a later `xi_n` pulse. The read token is handled the same way at address `DEPTH-1`.
- R7: `full` is high when the slice holds `DEPTH` words, and `empty` is high when it holds none. `wr_en` is never high while the slice is full, and `rd_en` is never high while it is empty.
- R8: The ring closes: a pulse from the last slice gives the write token back to the head, which then writes at address 0.
- R9: In single mode, `half_full` is high exactly when the slice holds more than `DEPTH/2` words. In cascade mode it is always low.
- R10: In single mode, `rewind_req` sets the read address to 0 and sets the occupancy to the current write address. In cascade mode it has no effect.
- R11: `wr_addr` and `rd_addr` are 0 after reset. Each advances by one for every enable and wraps from `DEPTH-1` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the mode is sampled while it is low |
| first_n | input | 1 | Low marks the head slice of a cascade |
| xi_n | input | 1 | Expansion input from the previous slice, active-low pulse; grounded for single mode |
| wr_req | input | 1 | Shared write request |
| rd_req | input | 1 | Shared read request |
| rewind_req | input | 1 | Restart reading at address 0 (single mode only) |
| wr_en | output | 1 | Write strobe to this slice's storage |
| wr_addr | output | $clog2(DEPTH) | Storage write address |
| rd_en | output | 1 | Read strobe to this slice's storage |
| rd_addr | output | $clog2(DEPTH) | Storage read address |
| xo_n | output | 1 | Expansion output to the next slice, active-low one-cycle pulse |
| full | output | 1 | Slice holds DEPTH words |
| empty | output | 1 | Slice holds no words |
| half_full | output | 1 | More than DEPTH/2 words held (single mode) |

## Verification
A wrong token state is visible at the shared enables in the same cycle as the next request. A slice that wrongly keeps a token produces a second enable alongside its neighbour. A slice that loses a token leaves a request with no enable at all. Both cases show up at the first access after a hand-off. A wrong pulse-phase count in a follower moves its first read forward or backward by a whole pass of the ring, so the bench drives reads while the follower already holds data. A fault in a counter appears as a wrong address or flag within the next one to four accesses, and a wrongly applied rewind shows at once on `rd_addr`.

// File: rtl/dcas_pkg.sv
package dcas_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_HEAD   = 2'd1,
    MODE_FOLLOW = 2'd2
  } dcas_mode_e;

  localparam int TOK_WR  = 0;
  localparam int TOK_RD  = 1;
  localparam int TOK_CNT = 2;

  function automatic dcas_mode_e dcas_pick_mode(input logic xi_lvl_n, input logic first_lvl_n);
    if (!xi_lvl_n) return MODE_SINGLE;
    else if (!first_lvl_n) return MODE_HEAD;
    else return MODE_FOLLOW;
  endfunction

endpackage

// File: rtl/dcas_mode_latch.sv
module dcas_mode_latch
  import dcas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xi_n,
  input  logic       first_n,
  output dcas_mode_e mode
);
  // Follow the pins for as long as reset is held; freeze on release.
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= dcas_pick_mode(xi_n, first_n);
  end
endmodule

// File: rtl/dcas_xi_decode.sv
module dcas_xi_decode
  import dcas_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               xi_n,
  output logic [TOK_CNT-1:0] grant
);
  logic phase_q;   // 0: next pulse carries the write token, 1: the read token
  logic pulse;

  assign pulse         = active && !xi_n;
  assign grant[TOK_WR] = pulse && !phase_q;
  assign grant[TOK_RD] = pulse && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= 1'b0;
    else if (pulse) phase_q <= !phase_q;
  end
endmodule

// File: rtl/dcas_token.sv
module dcas_token (
  input  logic clk,
  input  logic rst_n,
  input  logic init_own,
  input  logic grant,
  input  logic give_up,
  output logic own
);
  always_ff @(posedge clk) begin
    if (!rst_n)       own <= init_own;
    else if (grant)   own <= 1'b1;
    else if (give_up) own <= 1'b0;
  end
endmodule

// File: rtl/dcas_ptrs.sv
module dcas_ptrs #(
  parameter  int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_inc,
  input  logic          rd_inc,
  input  logic          rewind,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] cnt
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_inc) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (rewind) begin
        rd_ptr <= '0;
        cnt    <= CW'(wr_ptr) + CW'(wr_inc);
      end else begin
        if (rd_inc) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
        cnt <= cnt + CW'(wr_inc) - CW'(rd_inc);
      end
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_ptr_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(cnt) == AW'(wr_ptr - rd_ptr));
endmodule

// File: rtl/dcas_slice_ctrl.sv
module dcas_slice_ctrl
  import dcas_pkg::*;
#(
  parameter  int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_n,
  input  logic          xi_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          rewind_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          xo_n,
  output logic          full,
  output logic          empty,
  output logic          half_full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  dcas_mode_e         mode;
  logic               cascade;
  logic               head_now;
  logic [TOK_CNT-1:0] tok_grant, tok_rel, tok_own, tok_ok;
  logic [CW-1:0]      cnt;
  logic               rewind;

  dcas_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .xi_n(xi_n), .first_n(first_n), .mode(mode)
  );

  assign cascade  = (mode != MODE_SINGLE);
  assign head_now = (dcas_pick_mode(xi_n, first_n) == MODE_HEAD);

  dcas_xi_decode u_xi (
    .clk(clk), .rst_n(rst_n), .active(cascade), .xi_n(xi_n), .grant(tok_grant)
  );

  for (genvar g = 0; g < TOK_CNT; g++) begin : g_tok
    dcas_token u_tok (
      .clk(clk), .rst_n(rst_n), .init_own(head_now),
      .grant(tok_grant[g]), .give_up(tok_rel[g]), .own(tok_own[g])
    );
    assign tok_ok[g] = !cascade || tok_own[g];
  end

  dcas_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_inc(wr_en), .rd_inc(rd_en), .rewind(rewind),
    .wr_ptr(wr_addr), .rd_ptr(rd_addr), .cnt(cnt)
  );

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign half_full = !cascade && (cnt > HALF);
  assign rewind    = rewind_req && !cascade;

  assign wr_en = wr_req && tok_ok[TOK_WR] && !full;
  assign rd_en = rd_req && tok_ok[TOK_RD] && !empty && !rewind;

  assign tok_rel[TOK_WR] = cascade && wr_en && (wr_addr == LAST);
  assign tok_rel[TOK_RD] = cascade && rd_en && (rd_addr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) xo_n <= 1'b1;
    else        xo_n <= !(|tok_rel);
  end

  assert_single_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SINGLE) |-> xo_n);

  assert_wr_token_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && wr_en && wr_addr == LAST) |=> !tok_own[TOK_WR]);

  assert_rd_token_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && rd_en && rd_addr == LAST) |=> !tok_own[TOK_RD]);
endmodule

// File: tb/dcas_slice_ctrl_tb.sv
module dcas_slice_ctrl_tb;
  localparam int DEPTH = 4;
  localparam int AW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0, rewind_req = 1'b0;
  logic single_sel = 1'b0;

  logic h_we, h_re, h_xo, h_full, h_empty, h_hf;
  logic t_we, t_re, t_xo, t_full, t_empty, t_hf;
  logic [AW-1:0] h_wa, h_ra, t_wa, t_ra;
  logic h_xi;

  int checks = 0;
  int failures = 0;

  always #10 clk = !clk;

  assign h_xi = single_sel ? 1'b0 : t_xo;

  dcas_slice_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .first_n(1'b0), .xi_n(h_xi),
    .wr_req(wr_req), .rd_req(rd_req), .rewind_req(rewind_req),
    .wr_en(h_we), .wr_addr(h_wa), .rd_en(h_re), .rd_addr(h_ra),
    .xo_n(h_xo), .full(h_full), .empty(h_empty), .half_full(h_hf)
  );

  dcas_slice_ctrl #(.DEPTH(DEPTH)) u_tail (
    .clk(clk), .rst_n(rst_n), .first_n(1'b1), .xi_n(h_xo),
    .wr_req(wr_req), .rd_req(rd_req), .rewind_req(rewind_req),
    .wr_en(t_we), .wr_addr(t_wa), .rd_en(t_re), .rd_addr(t_ra),
    .xo_n(t_xo), .full(t_full), .empty(t_empty), .half_full(t_hf)
  );

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, got, exp);
    end
  endtask

  // drive at the falling edge, then look at the outputs 1 ns later
  task automatic drive(input logic w, input logic r, input logic rw);
    @(negedge clk);
    wr_req = w; rd_req = r; rewind_req = rw;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; rewind_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // bits: [9]wr [8]rd [7]Hwe [6]Twe [5]Hre [4]Tre [3]Hxo [2]Txo [1]Hfull [0]Hhf
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    10'b1010001100, 10'b1010001100, 10'b1010001100, 10'b1010001100,
    10'b1000000110, 10'b1001001110, 10'b0100101110, 10'b0100101100,
    10'b0100101100, 10'b0100101100, 10'b0100000100, 10'b0100011100,
    10'b1101001100, 10'b0100011100, 10'b0100001100, 10'b1001001100,
    10'b1001001100, 10'b1000001000, 10'b1010001100
  };

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hwa = 0, hra = 0, twa = 0, tra = 0;
    do_reset();
    #1;
    // R2 R5 R7 R11: state right after reset
    chk("R5 head xo idle", h_xo, 1);
    chk("R7 head empty at reset", h_empty, 1);
    chk("R11 head wr_addr reset", h_wa, 0);

    // cascade ring walk: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9], VEC[i][8], 1'b0);
      chk($sformatf("R2/R6 head wr_en step %0d", i), h_we, VEC[i][7]);
      chk($sformatf("R3/R8 tail wr_en step %0d", i), t_we, VEC[i][6]);
      chk($sformatf("R6 head rd_en step %0d", i), h_re, VEC[i][5]);
      chk($sformatf("R4 tail rd_en step %0d", i), t_re, VEC[i][4]);
      chk($sformatf("R5 head xo_n step %0d", i), h_xo, VEC[i][3]);
      chk($sformatf("R5 tail xo_n step %0d", i), t_xo, VEC[i][2]);
      chk($sformatf("R7 head full step %0d", i), h_full, VEC[i][1]);
      chk($sformatf("R9 head half_full cascade step %0d", i), h_hf, VEC[i][0]);
      chk($sformatf("R11 head wr_addr step %0d", i), h_wa, hwa);
      chk($sformatf("R11 tail wr_addr step %0d", i), t_wa, twa);
      chk($sformatf("R11 head rd_addr step %0d", i), h_ra, hra);
      chk($sformatf("R11 tail rd_addr step %0d", i), t_ra, tra);
      if (VEC[i][7]) hwa = (hwa + 1) % DEPTH;
      if (VEC[i][6]) twa = (twa + 1) % DEPTH;
      if (VEC[i][5]) hra = (hra + 1) % DEPTH;
      if (VEC[i][4]) tra = (tra + 1) % DEPTH;
    end

    // R10: rewind ignored in cascade (tail read address is 2, two words held)
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk("R10 cascade rewind ignored rd_addr", t_ra, 2);
    chk("R10 cascade rewind ignored empty", t_empty, 0);

    // single mode on the head slice
    single_sel = 1'b1;
    do_reset();
    #1;
    chk("R7 single empty after reset", h_empty, 1);
    chk("R9 single half_full after reset", h_hf, 0);
    drive(1'b0, 1'b1, 1'b0);
    chk("R7 no read while empty", h_re, 0);
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b0, 1'b0);
      chk("R1 single write enabled", h_we, 1);
      chk("R11 single wr_addr", h_wa, i);
    end
    drive(1'b0, 1'b0, 1'b0);
    chk("R9 half_full with 3 of 4", h_hf, 1);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b1, 1'b0);
      chk("R1 single read enabled", h_re, 1);
      chk("R11 single rd_addr", h_ra, i);
    end
    drive(1'b0, 1'b0, 1'b0);
    chk("R7 empty after draining", h_empty, 1);
    chk("R9 half_full cleared", h_hf, 0);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk("R10 rewind rd_addr", h_ra, 0);
    chk("R10 rewind refills", h_empty, 0);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b1, 1'b0);
      chk("R10 reread after rewind", h_re, 1);
      chk("R10 reread address", h_ra, i);
    end
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b0, 1'b0);
      chk("R1 single write to fill", h_we, 1);
      chk("R11 wr_addr wraps", h_wa, (3 + i) % DEPTH);
      if (i == 1) chk("R1 no xo pulse after last address", h_xo, 1);
    end
    drive(1'b1, 1'b0, 1'b0);
    chk("R7 full flag", h_full, 1);
    chk("R7 write blocked while full", h_we, 0);
    chk("R1 xo quiet in single mode", h_xo, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule